// File: doc/BRIEF.md
# Flash Interrupt and Status Controller

This block keeps the interrupt state of a NAND-style flash interface. It holds four registers: a controller status word with error flags, an interrupt status word with a master flag and per-operation done flags, and two system configuration words. Software uses a 16-bit register bus with separate read and write strobes. Reads return data one cycle after the strobe. A command engine outside the block reports completions and failures through single-cycle pulses. The block turns these pulses into register bits, an interrupt pin and a ready pin.

The block also guards the command register. A command written while the master interrupt flag is set is dropped. A known command written while the flag is clear is passed to the engine as a one-cycle issue strobe with its code. An unrecognised code is never issued; the block flags it as an error instead. Software acknowledges events by writing an AND-mask to the interrupt register. Clearing the master flag this way also wipes every error flag in the status word. A warm-reset pulse from the engine reloads the registers with their warm values. The active-low reset input loads the cold values.

Top module: `flash_irq_ctrl`

## Requirements
- R1: After the asynchronous reset, the registers read as follows: configuration-1 0x40C0, configuration-2 0x0000, status 0x0000, interrupt status 0x8080, command 0x0000. `irq_o` and `rdy_o` are both 1.
- R2: Writing offset 4 replaces interrupt status with (old value AND written value). Such a write can never set a bit.
- R3: If interrupt status bit 15 is 0 after the AND of an interrupt-register write, status bits 13..10 are cleared. If bit 15 is still 1, the status word is kept.
- R4: A pulse on `evt_done[i]` sets interrupt status bit 4+i and bit 15. The indices are 0 reset, 1 erase, 2 program and 3 load. A pulse on `evt_generic` sets only bit 15.
- R5: A pulse on `evt_err[j]` sets status bit 11+j and also the command-error bit 10. The indices are 0 erase, 1 program and 2 load.
- R6: Event pulses that arrive in the same cycle as an interrupt-register write are applied after the AND-mask and after the error wipe, so the event is kept.
- R7: A write to the command register (offset 0) while interrupt status bit 15 is 1 is dropped. `cmd_issue` stays 0 and the command register keeps its value.
- R8: A command write while bit 15 is 0 stores the value. If the value is a known code, `cmd_issue` is 1 for exactly the cycle after the write and `cmd_code` shows the value. The known codes are 0x00, 0x13, 0x80, 0x1A, 0x1B, 0x23, 0x27, 0x2A, 0x2C, 0x71, 0x94, 0x95, 0xB0, 0x30, 0xF0, 0xF3 and 0x65.
- R9: An accepted write of any other code does not pulse `cmd_issue`. It sets status bit 10 and interrupt status bit 15.
- R10: `irq_o` equals interrupt status bit 15 XOR the inverse of configuration-1 bit 6. With bit 6 at 1 the pin is active high; with bit 6 at 0 the pin is inverted.
- R11: `rdy_o` follows configuration-1 bit 7. A read of configuration-1 (offset 1) returns the stored value with bits 4..0 forced to 0. Configuration-2 (offset 2) reads back exactly what was written.
- R12: A pulse on `evt_warm` overrides any same-cycle event or write. After it, configuration-1 reads 0x40C0, configuration-2 reads 0, status reads 0, command reads 0 and interrupt status reads 0x8010.
- R13: `reg_rdata` shows the selected register in the cycle after a `reg_rd` strobe. Offsets 5 to 15 read 0. Writes to status (offset 3) and to unused offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (cold) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid one cycle after `reg_rd` |
| evt_done | input | 4 | Completion pulses: reset, erase, program, load |
| evt_generic | input | 1 | Completion pulse with no specific done flag |
| evt_err | input | 3 | Failure pulses: erase, program, load |
| evt_warm | input | 1 | Warm/command reset pulse |
| cmd_issue | output | 1 | One-cycle strobe for an accepted known command |
| cmd_code | output | 16 | Current command register value |
| irq_o | output | 1 | Interrupt pin, polarity from configuration-1 bit 6 |
| rdy_o | output | 1 | Ready pin, from configuration-1 bit 7 |

## Verification
The assertions assume the bus never raises `reg_rd` and `reg_wr` in the same cycle. The bench keeps the two strobes apart, because every access goes through its own one-cycle task.

The assertions also assume that event pulses are only one cycle wide. Events are allowed to coincide with a bus write. The bench creates that overlap on purpose to exercise R6.

The interrupt mask is swept over all 32 patterns of the master and done bits. Every 8-bit command code is written with the master flag cleared, so each code is classified. Each expected value is worked out in the bench from the bit positions and code list given in the requirements.

// File: rtl/fic_pkg.sv
package fic_pkg;
  localparam int DW        = 16;
  localparam int N_DONE    = 4;
  localparam int N_ERR     = 3;
  localparam int IB_MASTER = 15;
  localparam int IB_DONE0  = 4;
  localparam int SB_CMD    = 10;
  localparam int SB_ERR0   = 11;
  localparam int CB_IRQPOL = 6;
  localparam int CB_RDY    = 7;
  localparam int CFG1_LOW_ZERO = 5;

  localparam int OFF_CMD  = 0;
  localparam int OFF_CFG1 = 1;
  localparam int OFF_CFG2 = 2;
  localparam int OFF_STAT = 3;
  localparam int OFF_IST  = 4;

  localparam logic [DW-1:0] CFG1_RST = 16'h40C0;
  localparam logic [DW-1:0] IST_COLD = 16'h8080;
  localparam logic [DW-1:0] IST_WARM = 16'h8010;

  function automatic logic cmd_known(input logic [DW-1:0] c);
    case (c)
      16'h0000, 16'h0013, 16'h0080, 16'h001A, 16'h001B,
      16'h0023, 16'h0027, 16'h002A, 16'h002C, 16'h0071,
      16'h0094, 16'h0095, 16'h00B0, 16'h0030, 16'h00F0,
      16'h00F3, 16'h0065: cmd_known = 1'b1;
      default:            cmd_known = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/fic_event_regs.sv
module fic_event_regs
  import fic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm,
  input  logic              ist_wr,
  input  logic [DW-1:0]     wdata,
  input  logic [N_DONE-1:0] evt_done,
  input  logic              evt_generic,
  input  logic [N_ERR-1:0]  evt_err,
  input  logic              cmd_bad,
  output logic [DW-1:0]     ist_q,
  output logic [DW-1:0]     stat_q
);
  localparam logic [DW-1:0] ERR_FIELD =
    DW'(((1 << (N_ERR + 1)) - 1) << SB_CMD);

  logic [DW-1:0] ist_m, stat_m, ist_d, stat_d;
  logic          upd;

  always_comb begin
    ist_m  = ist_wr ? (ist_q & wdata) : ist_q;
    stat_m = (ist_wr && !ist_m[IB_MASTER]) ? (stat_q & ~ERR_FIELD) : stat_q;
    ist_d  = ist_m;
    stat_d = stat_m;
    for (int i = 0; i < N_DONE; i++) begin
      if (evt_done[i]) begin
        ist_d[IB_DONE0 + i] = 1'b1;
        ist_d[IB_MASTER]    = 1'b1;
      end
    end
    if (evt_generic || cmd_bad) ist_d[IB_MASTER] = 1'b1;
    for (int j = 0; j < N_ERR; j++) begin
      if (evt_err[j]) begin
        stat_d[SB_ERR0 + j] = 1'b1;
        stat_d[SB_CMD]      = 1'b1;
      end
    end
    if (cmd_bad) stat_d[SB_CMD] = 1'b1;
    if (warm) begin
      ist_d  = IST_WARM;
      stat_d = '0;
    end
  end

  assign upd = warm | ist_wr | (|evt_done) | evt_generic | (|evt_err) | cmd_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ist_q  <= IST_COLD;
      stat_q <= '0;
    end else if (upd) begin
      ist_q  <= ist_d;
      stat_q <= stat_d;
    end
  end

  AST_MASK_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ist_wr && !warm && !(|evt_done) && !evt_generic && !cmd_bad)
      |=> ((ist_q & ~($past(ist_q) & $past(wdata))) == '0)); // R2

  AST_ERR_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
    (ist_wr && !(ist_q[IB_MASTER] && wdata[IB_MASTER]) && !(|evt_err) && !cmd_bad)
      |=> ((stat_q & ERR_FIELD) == '0)); // R3

  AST_DONE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ((|evt_done) && !warm)
      |=> (ist_q[IB_MASTER] && ((ist_q[IB_DONE0 +: N_DONE] & $past(evt_done)) == $past(evt_done)))); // R6

  AST_ERR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (|stat_q[SB_ERR0 +: N_ERR]) |-> stat_q[SB_CMD]); // R5

  AST_WARM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    warm |=> (ist_q == IST_WARM && stat_q == '0)); // R12
endmodule

// File: rtl/fic_cmd_gate.sv
module fic_cmd_gate
  import fic_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          warm,
  input  logic          cmd_wr,
  input  logic [DW-1:0] wdata,
  input  logic          blocked,
  output logic [DW-1:0] cmd_q,
  output logic          issue_q,
  output logic          cmd_bad
);
  logic          accept, known;
  logic [DW-1:0] cmd_d;
  logic          issue_d, cmd_en;

  always_comb begin
    accept  = cmd_wr && !blocked && !warm;
    known   = cmd_known(wdata);
    cmd_bad = accept && !known;
    issue_d = accept && known;
    cmd_en  = accept || warm;
    cmd_d   = warm ? '0 : wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      issue_q <= 1'b0;
    end else begin
      issue_q <= issue_d;
      if (cmd_en) cmd_q <= cmd_d;
    end
  end

  AST_CMD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && blocked && !warm) |=> (!issue_q && cmd_q == $past(cmd_q))); // R7

  AST_ISSUE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_q |=> !issue_q); // R8
endmodule

// File: rtl/fic_cfg_regs.sv
module fic_cfg_regs
  import fic_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          warm,
  input  logic          wr1,
  input  logic          wr2,
  input  logic [DW-1:0] wdata,
  input  logic          ist_master,
  output logic [DW-1:0] cfg1_q,
  output logic [DW-1:0] cfg2_q,
  output logic          irq_o,
  output logic          rdy_o
);
  logic [DW-1:0] cfg1_d, cfg2_d;
  logic          en1, en2;

  always_comb begin
    en1    = wr1 || warm;
    en2    = wr2 || warm;
    cfg1_d = warm ? CFG1_RST : wdata;
    cfg2_d = warm ? '0 : wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg1_q <= CFG1_RST;
      cfg2_q <= '0;
    end else begin
      if (en1) cfg1_q <= cfg1_d;
      if (en2) cfg2_q <= cfg2_d;
    end
  end

  assign irq_o = ist_master ^ ~cfg1_q[CB_IRQPOL];
  assign rdy_o = cfg1_q[CB_RDY];

  AST_RDY_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr1 && !warm) |=> (rdy_o == $past(wdata[CB_RDY]))); // R11
endmodule

// File: rtl/flash_irq_ctrl.sv
module flash_irq_ctrl
  import fic_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic [3:0]        evt_done,
  input  logic              evt_generic,
  input  logic [2:0]        evt_err,
  input  logic              evt_warm,
  output logic              cmd_issue,
  output logic [15:0]       cmd_code,
  output logic              irq_o,
  output logic              rdy_o
);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFF_CMD);
  localparam logic [ADDR_W-1:0] A_CFG1 = ADDR_W'(OFF_CFG1);
  localparam logic [ADDR_W-1:0] A_CFG2 = ADDR_W'(OFF_CFG2);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_IST  = ADDR_W'(OFF_IST);
  localparam logic [DW-1:0] CFG1_RD_MASK = ~DW'((1 << CFG1_LOW_ZERO) - 1);

  logic          wr_cmd, wr_cfg1, wr_cfg2, wr_ist;
  logic [DW-1:0] ist_q, stat_q, cmd_q, cfg1_q, cfg2_q;
  logic          cmd_bad;
  logic [DW-1:0] rd_d, rdata_q;

  always_comb begin
    wr_cmd  = reg_wr && (reg_addr == A_CMD);
    wr_cfg1 = reg_wr && (reg_addr == A_CFG1);
    wr_cfg2 = reg_wr && (reg_addr == A_CFG2);
    wr_ist  = reg_wr && (reg_addr == A_IST);
  end

  fic_event_regs u_evt (
    .clk         (clk),
    .rst_n       (rst_n),
    .warm        (evt_warm),
    .ist_wr      (wr_ist),
    .wdata       (reg_wdata),
    .evt_done    (evt_done),
    .evt_generic (evt_generic),
    .evt_err     (evt_err),
    .cmd_bad     (cmd_bad),
    .ist_q       (ist_q),
    .stat_q      (stat_q)
  );

  fic_cmd_gate u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .warm    (evt_warm),
    .cmd_wr  (wr_cmd),
    .wdata   (reg_wdata),
    .blocked (ist_q[IB_MASTER]),
    .cmd_q   (cmd_q),
    .issue_q (cmd_issue),
    .cmd_bad (cmd_bad)
  );

  fic_cfg_regs u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .warm       (evt_warm),
    .wr1        (wr_cfg1),
    .wr2        (wr_cfg2),
    .wdata      (reg_wdata),
    .ist_master (ist_q[IB_MASTER]),
    .cfg1_q     (cfg1_q),
    .cfg2_q     (cfg2_q),
    .irq_o      (irq_o),
    .rdy_o      (rdy_o)
  );

  always_comb begin
    case (reg_addr)
      A_CMD:   rd_d = cmd_q;
      A_CFG1:  rd_d = cfg1_q & CFG1_RD_MASK;
      A_CFG2:  rd_d = cfg2_q;
      A_STAT:  rd_d = stat_q;
      A_IST:   rd_d = ist_q;
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (reg_rd) rdata_q <= rd_d;
  end

  assign reg_rdata = rdata_q;
  assign cmd_code  = cmd_q;

  AST_BUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_wr)); // R13

  AST_IRQ_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg1_q[CB_IRQPOL] && ist_q[IB_MASTER]) |-> irq_o); // R10
endmodule

// File: tb/tb_flash_irq_ctrl.sv
module tb_flash_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [3:0]  evt_done = '0;
  logic        evt_generic = 1'b0;
  logic [2:0]  evt_err = '0;
  logic        evt_warm = 1'b0;
  logic        cmd_issue, irq_o, rdy_o;
  logic [15:0] cmd_code;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  flash_irq_ctrl #(.ADDR_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_done(evt_done), .evt_generic(evt_generic), .evt_err(evt_err),
    .evt_warm(evt_warm), .cmd_issue(cmd_issue), .cmd_code(cmd_code),
    .irq_o(irq_o), .rdy_o(rdy_o)
  );

  function automatic logic ref_known(input logic [15:0] c);
    logic [7:0] lst [17] = '{8'h00, 8'h13, 8'h80, 8'h1A, 8'h1B, 8'h23, 8'h27,
                             8'h2A, 8'h2C, 8'h71, 8'h94, 8'h95, 8'hB0, 8'h30,
                             8'hF0, 8'hF3, 8'h65};
    ref_known = 1'b0;
    if (c[15:8] == 8'h00)
      for (int k = 0; k < 17; k++) if (lst[k] == c[7:0]) ref_known = 1'b1;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic ev(input logic [3:0] dn, input logic g, input logic [2:0] e, input logic w);
    @(negedge clk);
    evt_done = dn; evt_generic = g; evt_err = e; evt_warm = w;
    @(negedge clk);
    evt_done = '0; evt_generic = 1'b0; evt_err = '0; evt_warm = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [15:0] v, msk, exp_i;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 cold reset values
    rd(4'd1, v); chk("R1 cfg1", v, 16'h40C0);
    rd(4'd2, v); chk("R1 cfg2", v, 16'h0000);
    rd(4'd3, v); chk("R1 status", v, 16'h0000);
    rd(4'd4, v); chk("R1 ist", v, 16'h8080);
    rd(4'd0, v); chk("R1 cmd", v, 16'h0000);
    chk("R1 irq", {15'd0, irq_o}, 16'd1);
    chk("R1 rdy", {15'd0, rdy_o}, 16'd1);

    // R13 unused offsets read zero
    for (int a = 5; a < 16; a++) begin
      rd(a[3:0], v); chk("R13 unused offset", v, 16'h0000);
    end

    // R7 command refused while master set
    wr(4'd0, 16'h0094);
    chk("R7 no issue", {15'd0, cmd_issue}, 16'd0);
    rd(4'd0, v); chk("R7 cmd unchanged", v, 16'h0000);

    // R2 R3 mask sweep over master+done bits
    for (int m = 0; m < 32; m++) begin
      wr(4'd4, 16'h0000);
      ev(4'hF, 1'b0, 3'b111, 1'b0);
      msk = {m[4], 7'd0, m[3:0], 4'hF} | 16'h7F0F;
      msk[15] = m[4];
      exp_i = 16'h80F0 & msk;
      wr(4'd4, msk);
      rd(4'd4, v); chk("R2 masked ist", v, exp_i);
      rd(4'd3, v); chk("R3 status after mask", v, exp_i[15] ? 16'h3C00 : 16'h0000);
    end

    // R4 each done source and generic
    for (int i = 0; i < 4; i++) begin
      wr(4'd4, 16'h0000);
      ev(4'(1 << i), 1'b0, 3'b000, 1'b0);
      rd(4'd4, v); chk("R4 done flag", v, 16'h8000 | 16'(1 << (4 + i)));
    end
    wr(4'd4, 16'h0000);
    ev(4'h0, 1'b1, 3'b000, 1'b0);
    rd(4'd4, v); chk("R4 generic", v, 16'h8000);

    // R5 each error source
    for (int j = 0; j < 3; j++) begin
      wr(4'd4, 16'h0000);
      ev(4'h0, 1'b0, 3'(1 << j), 1'b0);
      rd(4'd3, v); chk("R5 error pair", v, 16'h0400 | 16'(1 << (11 + j)));
    end

    // R6 events in the same cycle as a mask write survive
    ev(4'hF, 1'b0, 3'b111, 1'b0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'd4; reg_wdata = 16'h0000;
    evt_done = 4'b0100; evt_err = 3'b001;
    @(negedge clk);
    reg_wr = 1'b0; evt_done = '0; evt_err = '0;
    rd(4'd4, v); chk("R6 ist keeps event", v, 16'h8040);
    rd(4'd3, v); chk("R6 status keeps event", v, 16'h0C00);

    // R10 interrupt polarity
    wr(4'd4, 16'h0000);
    chk("R10 irq low active-high", {15'd0, irq_o}, 16'd0);
    wr(4'd1, 16'h0080);
    chk("R10 irq inverted idle", {15'd0, irq_o}, 16'd1);
    ev(4'h0, 1'b1, 3'b000, 1'b0);
    chk("R10 irq inverted asserted", {15'd0, irq_o}, 16'd0);
    wr(4'd1, 16'h40DF);
    chk("R10 irq active-high asserted", {15'd0, irq_o}, 16'd1);

    // R11 config readback and ready
    rd(4'd1, v); chk("R11 cfg1 low bits masked", v, 16'h40C0);
    chk("R11 rdy high", {15'd0, rdy_o}, 16'd1);
    wr(4'd1, 16'h4040);
    chk("R11 rdy low", {15'd0, rdy_o}, 16'd0);
    wr(4'd2, 16'hA5A5);
    rd(4'd2, v); chk("R11 cfg2", v, 16'hA5A5);

    // R8 R9 full sweep of 8-bit command codes
    for (int c = 0; c < 256; c++) begin
      logic kn;
      kn = ref_known(16'(c));
      wr(4'd4, 16'h0000);
      wr(4'd0, 16'(c));
      chk(kn ? "R8 issue strobe" : "R9 no issue", {15'd0, cmd_issue}, {15'd0, kn});
      chk("R8 cmd_code", cmd_code, 16'(c));
      @(negedge clk);
      chk("R8 strobe one cycle", {15'd0, cmd_issue}, 16'd0);
      rd(4'd4, v); chk("R9 master on unknown", v, kn ? 16'h0000 : 16'h8000);
      rd(4'd3, v); chk("R9 cmd error on unknown", v, kn ? 16'h0000 : 16'h0400);
    end

    // R13 writes to status are ignored
    ev(4'h0, 1'b0, 3'b010, 1'b0);
    wr(4'd3, 16'hFFFF);
    rd(4'd3, v); chk("R13 status read-only", v, 16'h1400);

    // R12 warm reset
    wr(4'd1, 16'h0000);
    ev(4'h8, 1'b1, 3'b100, 1'b1);
    rd(4'd1, v); chk("R12 cfg1", v, 16'h40C0);
    rd(4'd2, v); chk("R12 cfg2", v, 16'h0000);
    rd(4'd3, v); chk("R12 status", v, 16'h0000);
    rd(4'd4, v); chk("R12 ist", v, 16'h8010);
    rd(4'd0, v); chk("R12 cmd", v, 16'h0000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule